// File: doc/BRIEF.md
# Early/Late Vote and Decimating Loop Filter

This block forms the phase-tracking decisions of a 2x-oversampled, quarter-rate clock recovery loop. Each clock cycle brings one word: four data samples and four edge samples. The edge sample at position i lies between the data sample before it and data sample i. Each data-edge-data triple gives a bang-bang early or late bit. Two consecutive words are gathered into one half-rate decision. Each word first casts one early or late vote by majority within the word. The pair's early votes are then compared with its late votes.

A decimating run counter follows the comparison. It issues a single up or down pulse to the downstream phase counter only after enough consecutive decisions in the same direction. The `dec_sel` input sets the run length to 4 or 8, which trades tracking speed against dither on the recovered clock. Ties leave the run untouched. A decision against the current run direction drops the run back to its centre.

Top module: `el_vote_filter`

## Requirements
- R1: For position i of a word, the earlier data bit is d[i-1], or the previous word's d[3] when i = 0. The edge bit is e[i] and the later data bit is d[i]. When the two data bits differ, the position is early if the edge bit equals the later data bit, and late if it equals the earlier data bit. When the two data bits are equal, the position is neither early nor late.
- R2: Words are grouped in pairs, starting with the first clock edge after reset is released. A pair's up/dn result is registered on the clock edge that follows the edge sampling the pair's second word.
- R3: Each word gives an early vote when it has more early positions than late positions, and a late vote in the opposite case. A word with equal counts gives no vote.
- R4: A pair whose early votes outnumber its late votes is an early decision and advances the run toward an up pulse. A pair whose late votes outnumber its early votes is a late decision and advances the run toward a dn pulse.
- R5: A pair with equal early and late votes leaves the run state unchanged and produces no pulse.
- R6: With dec_sel = 0, an up (dn) pulse is issued on the 4th consecutive early (late) decision, counted from the centre. The run then returns to the centre.
- R7: With dec_sel = 1, the pulse requires 8 consecutive same-direction decisions.
- R8: A decision opposite to a non-empty run returns the run to the centre. It produces no pulse and is not counted toward the new direction.
- R9: up and dn are low in reset. Each is high for exactly one clock cycle per pulse, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-rate word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsamp | input | 4 | Data samples of the current word, bit 0 earliest |
| esamp | input | 4 | Edge samples; bit i precedes data sample i |
| dec_sel | input | 1 | Run length select: 0 gives 4 decisions, 1 gives 8 |
| up | output | 1 | One-cycle pulse: advance the sampling phase |
| dn | output | 1 | One-cycle pulse: retard the sampling phase |

## Verification
The bench uses the default run lengths of 4 and 8. Every pulse therefore falls within a few dozen words, and switching dec_sel mid-run exercises both limits against the same counter. Directed pairs reach the exact 3rd/4th and 7th/8th decision boundaries, runs interrupted by ties, and direction flips that must drain the run without a pulse. Random words with mixed edge placement also produce per-word vote ties and split pairs in which one word votes early and the other late.

// File: rtl/el_vote_filter.sv
module el_vote_filter #(
  parameter int DEC_LO = 4,
  parameter int DEC_HI = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dsamp,
  input  logic [3:0] esamp,
  input  logic       dec_sel,
  output logic       up,
  output logic       dn
);
  localparam int CW = $clog2(DEC_HI + 1);

  logic          d3_q, ph, hv, dir;
  logic [3:0]    lo_e, lo_l;
  logic [7:0]    ev8, lv8;
  logic [CW-1:0] run, lim, run_nx;
  logic [4:0]    chain;
  logic [3:0]    trans, early4, late4;
  logic [1:0]    ea, la;
  logic          early_dom, late_dom;

  assign chain  = {dsamp, d3_q};
  assign trans  = chain[3:0] ^ chain[4:1];
  assign early4 = trans & (chain[3:0] ^ esamp);
  assign late4  = trans & (chain[4:1] ^ esamp);

  assign ea[0] = $countones(ev8[3:0]) > $countones(lv8[3:0]);
  assign ea[1] = $countones(ev8[7:4]) > $countones(lv8[7:4]);
  assign la[0] = $countones(lv8[3:0]) > $countones(ev8[3:0]);
  assign la[1] = $countones(lv8[7:4]) > $countones(ev8[7:4]);

  assign early_dom = $countones(ea) > $countones(la);
  assign late_dom  = $countones(la) > $countones(ea);

  assign lim    = dec_sel ? CW'(DEC_HI) : CW'(DEC_LO);
  assign run_nx = run + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d3_q <= 1'b0;
      ph   <= 1'b0;
      hv   <= 1'b0;
      lo_e <= '0;
      lo_l <= '0;
      ev8  <= '0;
      lv8  <= '0;
    end else begin
      d3_q <= dsamp[3];
      ph   <= ~ph;
      hv   <= ph;
      if (!ph) begin
        lo_e <= early4;
        lo_l <= late4;
      end else begin
        ev8 <= {early4, lo_e};
        lv8 <= {late4, lo_l};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      dir <= 1'b0;
      up  <= 1'b0;
      dn  <= 1'b0;
    end else begin
      up <= 1'b0;
      dn <= 1'b0;
      if (hv && (early_dom || late_dom)) begin
        if (run != '0 && dir != early_dom) begin
          run <= '0;
        end else if (run_nx >= lim) begin
          run <= '0;
          up  <= early_dom;
          dn  <= late_dom;
        end else begin
          run <= run_nx;
          dir <= early_dom;
        end
      end
    end
  end
endmodule

// File: rtl/el_vote_filter_chk.sv
module el_vote_filter_chk #(
  parameter int DEC_HI = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hv,
  input logic [1:0]    ea,
  input logic [1:0]    la,
  input logic [CW-1:0] run,
  input logic          dir,
  input logic          up,
  input logic          dn
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));
  p_up_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) up |=> !up);
  p_dn_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) dn |=> !dn);
  p_pulse_after_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up || dn) |-> $past(hv));
  p_tie_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hv && $countones(ea) == $countones(la)) |=> ($stable(run) && !up && !dn));
  p_flip_centre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hv && $countones(ea) > $countones(la) && run != '0 && !dir) |=> (run == '0 && !up && !dn));
  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n) run < CW'(DEC_HI));
endmodule

bind el_vote_filter el_vote_filter_chk #(.DEC_HI(DEC_HI), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hv(hv), .ea(ea), .la(la),
  .run(run), .dir(dir), .up(up), .dn(dn)
);

// File: tb/el_vote_filter_test.sv
`timescale 1ns/1ps
module el_vote_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] dsamp = '0, esamp = '0;
  logic dec_sel = 1'b0;
  logic up, dn;

  int checks = 0, errors = 0;
  int run_m = 0;
  bit dir_m = 1'b0;
  bit prev3 = 1'b0;
  bit exp_up = 1'b0, exp_dn = 1'b0;
  string pend_tag = "R9";
  bit done = 1'b0;

  el_vote_filter uut (.clk(clk), .rst_n(rst_n), .dsamp(dsamp), .esamp(esamp),
                      .dec_sel(dec_sel), .up(up), .dn(dn));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic au, logic ad, logic eu, logic ed);
    checks++;
    if (au !== eu || ad !== ed) begin
      errors++;
      $display("FAIL %s up/dn=%b%b expected %b%b", tag, au, ad, eu, ed);
    end
  endtask

  function automatic logic [1:0] word_vote(bit p, logic [3:0] d, logic [3:0] e);
    int ne = 0, nl = 0;
    for (int i = 0; i < 4; i++) begin
      logic a;
      a = (i == 0) ? p : d[i-1];
      if (a != d[i]) begin
        if (e[i] == d[i]) ne++;
        else nl++;
      end
    end
    return {ne > nl, nl > ne};
  endfunction

  function automatic logic [3:0] early_e(bit p, logic [3:0] d);
    return d;
  endfunction

  function automatic logic [3:0] late_e(bit p, logic [3:0] d);
    return {d[2:0], p};
  endfunction

  task automatic run_pair(logic [3:0] d0, logic [3:0] e0, logic [3:0] d1,
                          logic [3:0] e1, bit dsel, string tag);
    logic [1:0] v0, v1;
    int ne, nl, lim;
    chk("R9", up, dn, 1'b0, 1'b0);
    dsamp = d0; esamp = e0;
    @(negedge clk);
    chk(pend_tag, up, dn, exp_up, exp_dn);
    dsamp = d1; esamp = e1; dec_sel = dsel;
    v0 = word_vote(prev3, d0, e0);
    v1 = word_vote(d0[3], d1, e1);
    prev3 = d1[3];
    ne = v0[1] + v1[1];
    nl = v0[0] + v1[0];
    lim = dsel ? 8 : 4;
    exp_up = 1'b0; exp_dn = 1'b0;
    if (ne != nl) begin
      if (run_m != 0 && dir_m != (ne > nl)) run_m = 0;
      else if (run_m + 1 >= lim) begin
        run_m = 0;
        exp_up = (ne > nl);
        exp_dn = (nl > ne);
      end else begin
        run_m++;
        dir_m = (ne > nl);
      end
    end
    pend_tag = tag;
    @(negedge clk);
  endtask

  task automatic early_pair(bit dsel, string tag);
    logic [3:0] e0, e1;
    e0 = early_e(prev3, 4'b0101);
    e1 = early_e(1'b0, 4'b0101);
    run_pair(4'b0101, e0, 4'b0101, e1, dsel, tag);
  endtask

  task automatic late_pair(bit dsel, string tag);
    logic [3:0] e0, e1;
    e0 = late_e(prev3, 4'b0101);
    e1 = late_e(1'b0, 4'b0101);
    run_pair(4'b0101, e0, 4'b0101, e1, dsel, tag);
  endtask

  task automatic tie_pair(bit dsel, string tag);
    logic [3:0] d;
    d = {4{prev3}};
    run_pair(d, d, d, d, dsel, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", up, dn, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R6, R1, R4: four early decisions give one up pulse
    for (int k = 0; k < 4; k++) early_pair(1'b0, "R6 early run");
    // R6, R4: late run gives dn
    for (int k = 0; k < 4; k++) late_pair(1'b0, "R6 late run");
    // R5: ties interleaved do not break the run
    early_pair(1'b0, "R5"); early_pair(1'b0, "R5");
    for (int k = 0; k < 3; k++) tie_pair(1'b0, "R5 tie hold");
    early_pair(1'b0, "R5"); early_pair(1'b0, "R5 resume");
    // R8: flip drains the run without pulse
    for (int k = 0; k < 3; k++) early_pair(1'b0, "R8");
    late_pair(1'b0, "R8 flip");
    for (int k = 0; k < 3; k++) early_pair(1'b0, "R8 recount");
    early_pair(1'b0, "R8 after flip");
    // R7: eight decisions with dec_sel = 1
    for (int k = 0; k < 8; k++) late_pair(1'b1, "R7 long run");
    for (int k = 0; k < 8; k++) early_pair(1'b1, "R7 long run");
    // R3, R1, R2: split pair, one word early and one late
    run_pair(4'b0101, early_e(prev3, 4'b0101), 4'b0101, late_e(1'b1 ^ 1'b1, 4'b0101),
             1'b0, "R3 split pair");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [3:0] d0, d1, e0, e1;
      bit ds;
      d0 = 4'($urandom);
      d1 = 4'($urandom);
      e0 = 4'($urandom);
      e1 = 4'($urandom);
      if ($urandom_range(0, 2) == 0) e0 = early_e(prev3, d0);
      if ($urandom_range(0, 2) == 0) e1 = early_e(d0[3], d1);
      ds = ($urandom_range(0, 9) == 0) ? ~dec_sel : dec_sel;
      run_pair(d0, e0, d1, e1, ds, "R1 R3 R4 random");
    end
    tie_pair(1'b0, "R5 flush");
    tie_pair(1'b0, "R5 flush");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule